// File: doc/BRIEF.md
# Thread Slot Interleave Scheduler

This block decides, once per clock, which hardware thread context may issue into a single in-order pipeline. Its output is a valid flag and a thread tag. The tag is then passed down a chain of stage registers, so every pipeline stage knows which context's program counter and register state it is working on.

The policy input selects one of three schedulers. A rotating interleave gives every thread its own fixed turn. A programmable slot table is stepped through in order and issues the thread stored in each slot. A ready-based picker takes the lowest-numbered thread that is ready. In the first two modes, a slot whose owner is not ready becomes a bubble.

Table writes land in a shadow copy. The schedule in use is refreshed from that copy only between rotations, so a schedule that is only partly rewritten is never used.

Top module: `tsched_top`

## Requirements
- R1: A synchronous reset clears every stage valid and tag to 0, puts both rotation counters at 0, and sets every table slot to thread 0. After reset, a table-mode rotation with all threads ready issues only thread 0.
- R2: The policy field uses code 0 for rotating interleave. In that mode, the decision made in the k-th cycle after reset (counting from 0) is for thread k mod 4. That thread is issued when its ready bit is set.
- R3: In rotating mode, if the owning thread is not ready, stage 0 shows valid=0 even when other threads are ready.
- R4: The policy field uses code 1 for table mode. In that mode, the k-th cycle after reset uses slot k mod 8 and issues the thread stored there when that thread is ready; otherwise it issues a bubble. Both counters run in every mode.
- R5: A table write changes the shadow copy at once. The active schedule takes it from the first slot-0 cycle after the write, including a write made in the cycle that uses slot 7.
- R6: The policy field uses code 2 for priority mode. In that mode, the lowest-numbered ready thread is issued.
- R7: In priority mode, when no thread is ready, stage 0 shows valid=0.
- R8: Policy code 3 issues only bubbles.
- R9: Stage 0 shows the decision one clock after it is made. Stage k (k = 1 to 4) shows what stage k-1 held one clock earlier, valid and tag together.
- R10: Once rotating mode has been held for 5 cycles, no valid tag in stages 1 to 3 matches a valid tag in stage 0. A thread's instruction therefore reaches write-back before that thread's next instruction reads registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready_i | input | 4 | Per-thread ready flags, bit n for thread n |
| policy_i | input | 2 | 0 rotating, 1 table, 2 priority, 3 bubbles |
| tbl_we_i | input | 1 | Slot table write enable |
| tbl_slot_i | input | 3 | Slot index to write |
| tbl_tid_i | input | 2 | Thread ID to store |
| stg_valid_o | output | 5 | Valid flag per stage, bit 0 is issue |
| stg_tid_o | output | 10 | Thread tag per stage, bits [2k+1:2k] for stage k |

## Verification
The hardest case to reach is a table write made in the cycle that uses slot 7, because it races the refresh of the active schedule. The bench keeps its own slot counter from reset. It times a write so that it lands in that last-slot cycle. It then checks that the new owner appears in the very next rotation, and that writes made in the middle of a rotation are held back until slot 0.

// File: rtl/tsched_pkg.sv
package tsched_pkg;
    localparam int unsigned THREADS = 4;
    localparam int unsigned SLOTS   = 8;
    localparam int unsigned STAGES  = 5;
    localparam int unsigned TID_W   = $clog2(THREADS);
    localparam int unsigned SLOT_W  = $clog2(SLOTS);
    localparam int unsigned RUN_W   = $clog2(STAGES + 1);

    typedef logic [TID_W-1:0]  tid_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [1:0] {
        POL_ROTATE = 2'd0,
        POL_TABLE  = 2'd1,
        POL_PRIO   = 2'd2,
        POL_OFF    = 2'd3
    } policy_e;

    typedef struct packed {
        logic valid;
        tid_t tid;
    } issue_t;

    function automatic tid_t next_tid(input tid_t t);
        return (t == TID_W'(THREADS - 1)) ? '0 : t + 1'b1;
    endfunction

    function automatic slot_t next_slot(input slot_t s);
        return (s == SLOT_W'(SLOTS - 1)) ? '0 : s + 1'b1;
    endfunction
endpackage

// File: rtl/tsched_slot_table.sv
module tsched_slot_table #(
    parameter int unsigned SLOTS  = 8,
    parameter int unsigned TID_W  = 2,
    parameter int unsigned SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [SLOT_W-1:0] wslot_i,
    input  logic [TID_W-1:0]  wtid_i,
    input  logic              commit_i,
    input  logic [SLOT_W-1:0] rslot_i,
    output logic [TID_W-1:0]  rtid_o
);
    logic [TID_W-1:0] shadow_q [SLOTS];
    logic [TID_W-1:0] shadow_d [SLOTS];
    logic [TID_W-1:0] active_q [SLOTS];
    logic [SLOTS*TID_W-1:0] active_flat;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            shadow_d[i] = (we_i && wslot_i == SLOT_W'(i)) ? wtid_i : shadow_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                shadow_q[i] <= '0;
                active_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                shadow_q[i] <= shadow_d[i];
                if (commit_i) active_q[i] <= shadow_d[i];
            end
        end
    end

    assign rtid_o = active_q[rslot_i];

    for (genvar g = 0; g < SLOTS; g++) begin : g_flat
        assign active_flat[g*TID_W +: TID_W] = active_q[g];
    end

    // Active schedule only moves at a rotation boundary (R5)
    assert_active_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(active_flat));
endmodule

// File: rtl/tsched_prio_pick.sv
module tsched_prio_pick #(
    parameter int unsigned THREADS = 4,
    parameter int unsigned TID_W   = 2
) (
    input  logic [THREADS-1:0] ready_i,
    output logic               found_o,
    output logic [TID_W-1:0]   tid_o
);
    always_comb begin
        found_o = 1'b0;
        tid_o   = '0;
        for (int i = THREADS - 1; i >= 0; i--) begin
            if (ready_i[i]) begin
                found_o = 1'b1;
                tid_o   = TID_W'(i);
            end
        end
    end
endmodule

// File: rtl/tsched_tag_pipe.sv
module tsched_tag_pipe #(
    parameter int unsigned STAGES = 5,
    parameter int unsigned TID_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    valid_i,
    input  logic [TID_W-1:0]        tid_i,
    output logic [STAGES-1:0]       valid_o,
    output logic [STAGES*TID_W-1:0] tid_o
);
    logic [STAGES-1:0] v_q;
    logic [TID_W-1:0]  t_q [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q[k] <= 1'b0;
                t_q[k] <= '0;
            end else if (k == 0) begin
                v_q[k] <= valid_i;
                t_q[k] <= tid_i;
            end else begin
                v_q[k] <= v_q[(k == 0) ? 0 : k - 1];
                t_q[k] <= t_q[(k == 0) ? 0 : k - 1];
            end
        end
        assign tid_o[k*TID_W +: TID_W] = t_q[k];
    end

    assign valid_o = v_q;
endmodule

// File: rtl/tsched_top.sv
module tsched_top
    import tsched_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [THREADS-1:0]      ready_i,
    input  logic [1:0]              policy_i,
    input  logic                    tbl_we_i,
    input  logic [SLOT_W-1:0]       tbl_slot_i,
    input  logic [TID_W-1:0]        tbl_tid_i,
    output logic [STAGES-1:0]       stg_valid_o,
    output logic [STAGES*TID_W-1:0] stg_tid_o
);
    tid_t    rr_q;
    slot_t   slot_q;
    tid_t    tbl_tid;
    tid_t    pri_tid;
    logic    pri_found;
    logic    wrap;
    issue_t  sel;
    policy_e pol;

    assign pol  = policy_e'(policy_i);
    assign wrap = (slot_q == SLOT_W'(SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q   <= '0;
            slot_q <= '0;
        end else begin
            rr_q   <= next_tid(rr_q);
            slot_q <= next_slot(slot_q);
        end
    end

    tsched_slot_table #(.SLOTS(SLOTS), .TID_W(TID_W), .SLOT_W(SLOT_W)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .we_i     (tbl_we_i),
        .wslot_i  (tbl_slot_i),
        .wtid_i   (tbl_tid_i),
        .commit_i (wrap),
        .rslot_i  (slot_q),
        .rtid_o   (tbl_tid)
    );

    tsched_prio_pick #(.THREADS(THREADS), .TID_W(TID_W)) u_pri (
        .ready_i (ready_i),
        .found_o (pri_found),
        .tid_o   (pri_tid)
    );

    always_comb begin
        unique case (pol)
            POL_ROTATE: sel = '{valid: ready_i[rr_q],    tid: rr_q};
            POL_TABLE:  sel = '{valid: ready_i[tbl_tid], tid: tbl_tid};
            POL_PRIO:   sel = '{valid: pri_found,        tid: pri_tid};
            default:    sel = '{valid: 1'b0,             tid: '0};
        endcase
    end

    tsched_tag_pipe #(.STAGES(STAGES), .TID_W(TID_W)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .valid_i (sel.valid),
        .tid_i   (sel.tid),
        .valid_o (stg_valid_o),
        .tid_o   (stg_tid_o)
    );

    // ---------------- assertions ----------------
    logic [RUN_W-1:0] rot_run_q;
    always_ff @(posedge clk) begin
        if (rst)                   rot_run_q <= '0;
        else if (pol != POL_ROTATE) rot_run_q <= '0;
        else if (rot_run_q != RUN_W'(STAGES)) rot_run_q <= rot_run_q + 1'b1;
    end

    assert_rotate_bubble_R3: assert property (@(posedge clk) disable iff (rst)
        (pol == POL_ROTATE && !ready_i[rr_q]) |=> !stg_valid_o[0]);

    assert_prio_issue_R6: assert property (@(posedge clk) disable iff (rst)
        (pol == POL_PRIO && ready_i != '0) |=> stg_valid_o[0]);

    assert_prio_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (pol == POL_PRIO && ready_i == '0) |=> !stg_valid_o[0]);

    assert_off_bubble_R8: assert property (@(posedge clk) disable iff (rst)
        (pol == POL_OFF) |=> !stg_valid_o[0]);

    for (genvar i = 1; i < STAGES; i++) begin : g_space
        if (i < THREADS) begin : g_chk
            assert_thread_spacing_R10: assert property (@(posedge clk) disable iff (rst)
                (rot_run_q == RUN_W'(STAGES) && stg_valid_o[0] && stg_valid_o[i])
                |-> (stg_tid_o[TID_W-1:0] != stg_tid_o[i*TID_W +: TID_W]));
        end
    end
endmodule

// File: tb/tsched_top_test.sv
`timescale 1ns/1ps
module tsched_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ready = '0;
    logic [1:0] pol = '0;
    logic       we = 1'b0;
    logic [2:0] wslot = '0;
    logic [1:0] wtid = '0;
    logic [4:0] sv;
    logic [9:0] st;

    int errors = 0;
    int checks = 0;

    int rr_m, slot_m;
    int shadow_m [8];
    int active_m [8];
    int hv [5];
    int ht [5];

    always #5 clk = ~clk;

    tsched_top uut (
        .clk(clk), .rst(rst), .ready_i(ready), .policy_i(pol),
        .tbl_we_i(we), .tbl_slot_i(wslot), .tbl_tid_i(wtid),
        .stg_valid_o(sv), .stg_tid_o(st)
    );

    // {policy[1:0], ready[3:0]}
    localparam int NV = 20;
    localparam logic [5:0] VEC [NV] = '{
        6'b00_1111, 6'b00_1111, 6'b00_1011, 6'b00_1111, 6'b00_1110,
        6'b00_0001, 6'b00_0100, 6'b00_1000, 6'b10_1100, 6'b10_0000,
        6'b10_0110, 6'b10_1111, 6'b10_1000, 6'b11_1111, 6'b11_0101,
        6'b01_1111, 6'b01_0000, 6'b01_0001, 6'b10_0010, 6'b00_0000
    };

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; we = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rr_m = 0; slot_m = 0;
        for (int i = 0; i < 8; i++) begin shadow_m[i] = 0; active_m[i] = 0; end
        for (int k = 0; k < 5; k++) begin hv[k] = 0; ht[k] = 0; end
    endtask

    // Called at a negedge; returns at the following negedge after checking.
    task automatic step(input logic [1:0] p, input logic [3:0] r,
                        input bit w, input int ws, input int wt, input string tag);
        int ev, et;
        logic [4:0] expv;
        bit ok;
        pol = p; ready = r; we = w; wslot = 3'(ws); wtid = 2'(wt);
        ev = 0; et = 0;
        case (p)
            2'd0: begin et = rr_m; ev = r[rr_m]; end
            2'd1: begin et = active_m[slot_m]; ev = r[et]; end
            2'd2: begin
                for (int i = 3; i >= 0; i--) if (r[i]) begin ev = 1; et = i; end
            end
            default: ev = 0;
        endcase
        @(posedge clk);
        if (w) shadow_m[ws] = wt;
        if (slot_m == 7) for (int i = 0; i < 8; i++) active_m[i] = shadow_m[i];
        rr_m = (rr_m + 1) % 4;
        slot_m = (slot_m + 1) % 8;
        for (int k = 4; k > 0; k--) begin hv[k] = hv[k-1]; ht[k] = ht[k-1]; end
        hv[0] = ev; ht[0] = et;
        @(negedge clk);
        we = 1'b0;
        chk((sv[0] == hv[0]) && (!hv[0] || st[1:0] == ht[0]), tag,
            {sv[0], st[1:0]}, {hv[0], ht[0][1:0]});
        ok = 1'b1;
        for (int k = 1; k < 5; k++) begin
            expv[k] = hv[k][0];
            if (sv[k] != hv[k][0]) ok = 1'b0;
            if (hv[k] != 0 && st[2*k +: 2] != ht[k][1:0]) ok = 1'b0;
        end
        expv[0] = sv[0];
        chk(ok, "R9 stage tags", {sv, st}, {expv, st});
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        string tag;
        do_reset();
        // R1: state right after reset
        chk(sv == '0 && st == '0, "R1 reset outputs", {sv, st}, 0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0] p;
            logic [3:0] r;
            p = VEC[i][5:4];
            r = VEC[i][3:0];
            case (p)
                2'd0: tag = r[rr_m] ? "R2 rotate" : "R3 rotate bubble";
                2'd1: tag = "R4 table";
                2'd2: tag = (r == 0) ? "R7 prio idle" : "R6 prio";
                default: tag = "R8 off";
            endcase
            step(p, r, 1'b0, 0, 0, tag);
        end

        // R1: fresh table gives thread 0 for a whole rotation
        do_reset();
        for (int i = 0; i < 8; i++) step(2'd1, 4'b1111, 1'b0, 0, 0, "R1 table after reset");

        // R5: mid-rotation writes held until slot 0
        do_reset();
        step(2'd1, 4'b1111, 1'b1, 3, 2, "R5 write pending");
        step(2'd1, 4'b1111, 1'b1, 5, 1, "R5 write pending");
        for (int i = 0; i < 6; i++) step(2'd1, 4'b1111, 1'b0, 0, 0, "R5 old schedule");
        for (int i = 0; i < 8; i++) step(2'd1, 4'b1111, 1'b0, 0, 0, "R5 new schedule");
        // R5: write in the slot-7 cycle (slot_m is now 0)
        for (int i = 0; i < 7; i++) step(2'd1, 4'b1111, 1'b0, 0, 0, "R4 table");
        step(2'd1, 4'b1111, 1'b1, 0, 3, "R5 wrap write");
        step(2'd1, 4'b1111, 1'b0, 0, 0, "R5 wrap write visible");
        // R4: bubble when slot owner not ready
        for (int i = 0; i < 8; i++) step(2'd1, 4'b0011, 1'b0, 0, 0, "R4 table bubble");

        // R10: spacing in rotating mode
        for (int i = 0; i < 12; i++) begin
            bit ok;
            step(2'd0, 4'b1111, 1'b0, 0, 0, "R2 rotate");
            if (i >= 5) begin
                ok = 1'b1;
                for (int k = 1; k < 4; k++)
                    if (sv[0] && sv[k] && st[1:0] == st[2*k +: 2]) ok = 1'b0;
                chk(ok, "R10 spacing", st, 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule